// File: doc/BRIEF.md
# Dual-Lane Serial ADC Capture Controller

This block drives one 18-bit successive-approximation converter over a source-synchronous serial link and turns each conversion into a parallel word. While enabled, it raises a conversion-start pulse once per sample period. After a set conversion wait, it opens a gate and emits a short burst of shift clocks to the converter. The converter echoes that clock back as a data clock. The block samples the returned bits on the rising edges of the echoed clock, on one lane or on two lanes. It presents the finished word together with a one-cycle valid pulse.

All timing is counted in cycles of the system reference clock. The sample period, the high time of the start pulse and the conversion wait are parameters, and so is the lane mode. In two-lane mode a word takes 9 shift clocks, and in one-lane mode it takes 18. The block also drives three outputs toward the board:
- a conversion-enable line, which serves as the active-low clear of an external retiming flop;
- a lane-mode select line;
- registered copies of two control bits, power-down and test-pattern, that software writes.

Top module: `adc_serial_capture`

## Requirements
- R1: While enabled, `cnv` goes high for CNV_HIGH cycles at the start of every sample period of PERIOD cycles.
- R2: `cnv_en` follows `enable` one cycle later and is low out of reset. While `cnv_en` is low, `cnv`, `sclk` and `sclk_gate` stay low.
- R3: The first `sclk` rising edge comes exactly CONV_WAIT cycles after the `cnv` rising edge. `sclk` is high only while `sclk_gate` is high, and `sclk_gate` is never high together with `cnv`.
- R4: Each sample period carries exactly DATA_W/2 shift-clock pulses in two-lane mode and DATA_W in one-lane mode. Each pulse is one cycle high and one cycle low, and the burst ends before the next `cnv` rising edge.
- R5: In two-lane mode, each rising edge of `dco` captures `lane_a` and `lane_b` together, MSB first. `lane_a` carries sample bits DATA_W-1, DATA_W-3, … and `lane_b` carries bits DATA_W-2, DATA_W-4, ….
- R6: In one-lane mode, each rising edge of `dco` captures one bit from `lane_a`, MSB first, and `lane_b` has no effect on `sample_data`.
- R7: `sample_valid` is high for exactly one cycle, in the cycle after the edge that captured the final bit, and `sample_data` then holds the assembled word.
- R8: `lanes_sel` is 1 when TWO_LANE is 1 and 0 when TWO_LANE is 0.
- R9: `pd_out` and `testpat_out` equal `pd_req` and `testpat_req` delayed by one cycle, and both are 0 out of reset.
- R10: A word that the converter sends while `testpat_out` is high passes to `sample_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run conversions while high |
| pd_req | input | 1 | Software power-down bit |
| testpat_req | input | 1 | Software test-pattern bit |
| dco | input | 1 | Data clock echoed by the converter |
| lane_a | input | 1 | Serial data, first lane |
| lane_b | input | 1 | Serial data, second lane |
| cnv | output | 1 | Conversion start, active on rising edge |
| cnv_en | output | 1 | Active-low clear for external retiming flop |
| sclk | output | 1 | Gated shift clock to the converter |
| sclk_gate | output | 1 | Readout window enable |
| lanes_sel | output | 1 | Lane mode select to the converter |
| pd_out | output | 1 | Power-down control |
| testpat_out | output | 1 | Test-pattern enable |
| sample_data | output | 18 | Assembled sample word (DATA_W) |
| sample_valid | output | 1 | One-cycle strobe for sample_data |

## Verification
The bound assertions hold on every cycle for the following rules:
- no start pulse, gate or shift clock while the flop clear is low;
- shift clocks appear only inside the gate;
- the gate never overlaps the start pulse;
- a burst never holds more shift clocks than a word needs;
- the valid strobe never lasts two cycles;
- the control outputs track their requests with one cycle of delay.

Some behaviour can only be shown by the scenarios, which run a converter model in both lane modes. These are the exact period, the start width and the wait to the first shift clock. They also include the bit order on each lane, the fact that the second lane is ignored in one-lane mode, and the test-pattern words arriving intact. A second instance covers the one-lane mode.

// File: rtl/adc_cap_pkg.sv
// Shared helpers for the serial ADC capture block.
// Assumes DATA_W is even whenever two-lane mode is selected.
package adc_cap_pkg;

    // Number of shift clocks needed to move one word over the link.
    function automatic int burst_len(input int data_w, input int two_lane);
        return (two_lane != 0) ? (data_w + 1) / 2 : data_w;
    endfunction

endpackage

// File: rtl/adc_cnv_timer.sv
// Sample-period sequencer: counts reference-clock cycles and derives the
// conversion-start pulse, the readout gate, the gated shift clock and a
// frame marker aligned with the start pulse.
// Assumes CNV_HIGH <= CONV_WAIT and CONV_WAIT + 2*NCLK <= PERIOD.
module adc_cnv_timer #(
    parameter int PERIOD    = 32,
    parameter int CNV_HIGH  = 2,
    parameter int CONV_WAIT = 8,
    parameter int NCLK      = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic cnv_o,
    output logic gate_o,
    output logic sclk_o,
    output logic frame_o
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST_C = CW'(PERIOD - 1);
    localparam logic [CW-1:0] HIGH_C = CW'(CNV_HIGH);
    localparam logic [CW-1:0] WAIT_C = CW'(CONV_WAIT);
    localparam logic [CW-1:0] END_C  = CW'(CONV_WAIT + 2 * NCLK);

    logic [CW-1:0] cnt;
    logic [CW-1:0] offs;
    logic          in_gate;
    logic          cnv_q, gate_q, sclk_q, frame_q;

    // Period counter, held at zero while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || cnt == LAST_C) cnt <= '0;
        else                                 cnt <= cnt + 1'b1;
    end

    // Decode of the counter into the readout window and its phase.
    always_comb begin
        in_gate = (cnt >= WAIT_C) && (cnt < END_C);
        offs    = cnt - WAIT_C;
    end

    // Register the decoded strobes so the pins see no decode glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_q   <= 1'b0;
            gate_q  <= 1'b0;
            sclk_q  <= 1'b0;
            frame_q <= 1'b0;
        end else begin
            cnv_q   <= run && (cnt < HIGH_C);
            gate_q  <= run && in_gate;
            sclk_q  <= run && in_gate && !offs[0];
            frame_q <= run && (cnt == '0);
        end
    end

    // Qualify with run so a stop silences the pins at once.
    assign cnv_o   = cnv_q   && run;
    assign gate_o  = gate_q  && run;
    assign sclk_o  = sclk_q  && run;
    assign frame_o = frame_q && run;
endmodule

// File: rtl/adc_lane_deser.sv
// Deserialiser: shifts lane bits in MSB first on each rising edge of the
// echoed data clock (sampled in the reference domain) and emits the word
// after NCLK edges. A frame marker restarts the bit count.
// Assumes the echoed clock is high and low for at least one cycle each.
module adc_lane_deser #(
    parameter int DATA_W   = 18,
    parameter int TWO_LANE = 1,
    parameter int NCLK     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic              dco_i,
    input  logic              lane_a_i,
    input  logic              lane_b_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    localparam int BW = $clog2(NCLK + 1);
    localparam int SH = (TWO_LANE != 0) ? 0 : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(NCLK - 1);
    localparam logic [BW-1:0] NCLK_C   = BW'(NCLK);

    logic [DATA_W-1:0] shreg;
    logic [DATA_W+1:0] joined;
    logic [DATA_W-1:0] shifted;
    logic [BW-1:0]     bcnt;
    logic              dco_q;
    logic              dco_rise;

    // Next shift-register value; one-lane mode drops the second lane bit.
    always_comb begin
        joined   = {shreg, lane_a_i, lane_b_i};
        shifted  = DATA_W'(joined >> SH);
        dco_rise = dco_i && !dco_q;
    end

    // Capture lanes on data-clock edges and publish the finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bcnt    <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
            dco_q   <= 1'b0;
        end else begin
            dco_q   <= dco_i;
            valid_o <= 1'b0;
            if (frame_i) begin
                bcnt <= '0;
            end else if (dco_rise && bcnt < NCLK_C) begin
                shreg <= shifted;
                bcnt  <= bcnt + 1'b1;
                if (bcnt == LAST_BIT) begin
                    data_o  <= shifted;
                    valid_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_serial_capture.sv
// Top of the serial ADC capture block: registers the enable and the
// software control bits, runs the sample-period sequencer and the lane
// deserialiser, and drives the converter-side control pins.
// Assumes dco, lane_a and lane_b are already in the reference clock domain.
module adc_serial_capture #(
    parameter int DATA_W    = 18,
    parameter int TWO_LANE  = 1,
    parameter int PERIOD    = 32,
    parameter int CNV_HIGH  = 2,
    parameter int CONV_WAIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pd_req,
    input  logic              testpat_req,
    input  logic              dco,
    input  logic              lane_a,
    input  logic              lane_b,
    output logic              cnv,
    output logic              cnv_en,
    output logic              sclk,
    output logic              sclk_gate,
    output logic              lanes_sel,
    output logic              pd_out,
    output logic              testpat_out,
    output logic [DATA_W-1:0] sample_data,
    output logic              sample_valid
);
    import adc_cap_pkg::*;

    localparam int NCLK = burst_len(DATA_W, TWO_LANE);

    logic en_q, pd_q, tp_q;
    logic frame;

    // Register enable and software control bits toward the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            pd_q <= 1'b0;
            tp_q <= 1'b0;
        end else begin
            en_q <= enable;
            pd_q <= pd_req;
            tp_q <= testpat_req;
        end
    end

    adc_cnv_timer #(
        .PERIOD   (PERIOD),
        .CNV_HIGH (CNV_HIGH),
        .CONV_WAIT(CONV_WAIT),
        .NCLK     (NCLK)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en_q),
        .cnv_o  (cnv),
        .gate_o (sclk_gate),
        .sclk_o (sclk),
        .frame_o(frame)
    );

    adc_lane_deser #(
        .DATA_W  (DATA_W),
        .TWO_LANE(TWO_LANE),
        .NCLK    (NCLK)
    ) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (frame),
        .dco_i   (dco),
        .lane_a_i(lane_a),
        .lane_b_i(lane_b),
        .data_o  (sample_data),
        .valid_o (sample_valid)
    );

    assign cnv_en      = en_q;
    assign pd_out      = pd_q;
    assign testpat_out = tp_q;
    assign lanes_sel   = (TWO_LANE != 0);
endmodule

// File: rtl/adc_capture_checks.sv
// Protocol checker for adc_serial_capture, attached by bind below.
// Assumes the synchronous active-low reset of the checked block.
module adc_capture_checks #(
    parameter int NCLK = 9
) (
    input logic clk,
    input logic rst_n,
    input logic pd_req,
    input logic testpat_req,
    input logic cnv,
    input logic cnv_en,
    input logic sclk,
    input logic sclk_gate,
    input logic pd_out,
    input logic testpat_out,
    input logic sample_valid
);
    logic sclk_p, cnv_p;
    int   rises;

    // Count shift-clock pulses since the latest start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= 1'b0;
            cnv_p  <= 1'b0;
            rises  <= 0;
        end else begin
            sclk_p <= sclk;
            cnv_p  <= cnv;
            if (cnv && !cnv_p)        rises <= 0;
            else if (sclk && !sclk_p) rises <= rises + 1;
        end
    end

    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_en |-> (!cnv && !sclk && !sclk_gate));

    p_sclk_in_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> sclk_gate);

    p_gate_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnv |-> !sclk_gate);

    p_burst_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rises <= NCLK);

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    p_ctrl_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pd_out == $past(pd_req)) && (testpat_out == $past(testpat_req)));
endmodule

bind adc_serial_capture adc_capture_checks #(.NCLK(NCLK)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_req      (pd_req),
    .testpat_req (testpat_req),
    .cnv         (cnv),
    .cnv_en      (cnv_en),
    .sclk        (sclk),
    .sclk_gate   (sclk_gate),
    .pd_out      (pd_out),
    .testpat_out (testpat_out),
    .sample_valid(sample_valid)
);

// File: tb/adc_conv_model.sv
// Bench-side converter model and scoreboard for one capture instance.
// Driver: on each start pulse it picks a word, queues it as expected and
// serialises it on the echoed clock. Monitor: checks period, start width,
// wait to first shift clock and pulse count, and compares sample words.
module adc_conv_model #(
    parameter int DATA_W    = 18,
    parameter int TWO_LANE  = 1,
    parameter int PERIOD    = 32,
    parameter int CNV_HIGH  = 2,
    parameter int CONV_WAIT = 8,
    parameter int SEED      = 1
) (
    input  logic              clk,
    input  logic              cnv,
    input  logic              cnv_en,
    input  logic              sclk,
    input  logic              testpat,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] sample_data,
    output logic              dco,
    output logic              lane_a,
    output logic              lane_b,
    output int                n_chk,
    output int                n_fail,
    output int                n_samp
);
    localparam int NCLK = (TWO_LANE != 0) ? DATA_W / 2 : DATA_W;
    localparam logic [DATA_W-1:0] PATTERN = DATA_W'(18'h3C5A1);

    logic [DATA_W-1:0] exp_q[$];
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] got;
    int unsigned       lcg = SEED;
    int  cyc = 0, rise_cyc = 0, k = 0, pulses = 0, fidx = 0;
    bit  cnv_p = 0, sclk_p = 0, val_p = 0, have_prev = 0, first_seen = 0;
    bit  tp_word[$];
    bit  tpw;

    function automatic void check(input bit ok, input string tag,
                                  input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (lanes=%0d): actual %0h expected %0h",
                     tag, TWO_LANE, act, exp);
        end
    endfunction

    // Converter emulation and timing/data monitor, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        lcg = lcg * 1103515245 + 12345;
        if (!cnv_en) have_prev = 0;
        if (cnv && !cnv_p) begin
            if (have_prev) begin
                check(cyc - rise_cyc == PERIOD, "R1 period", cyc - rise_cyc, PERIOD);
                check(pulses == NCLK, "R4 shift clocks", pulses, NCLK);
            end
            have_prev  = 1;
            rise_cyc   = cyc;
            k          = 0;
            pulses     = 0;
            first_seen = 0;
            case (fidx)
                0: word = '1;
                1: word = '0;
                2: word = DATA_W'(18'h2AAAA);
                default: word = DATA_W'(lcg >> 7);
            endcase
            fidx++;
            if (testpat) word = PATTERN;
            exp_q.push_back(word);
            tp_word.push_back(testpat);
        end
        if (!cnv && cnv_p)
            check(cyc - rise_cyc == CNV_HIGH, "R1 cnv width", cyc - rise_cyc, CNV_HIGH);
        if (sclk && !sclk_p) begin
            if (!first_seen)
                check(cyc - rise_cyc == CONV_WAIT, "R3 first sclk", cyc - rise_cyc, CONV_WAIT);
            first_seen = 1;
            pulses++;
            if (k < NCLK) begin
                if (TWO_LANE != 0) begin
                    lane_a = word[DATA_W-1-2*k];
                    lane_b = word[DATA_W-2-2*k];
                end else begin
                    lane_a = word[DATA_W-1-k];
                    lane_b = lcg[20];
                end
            end
            k++;
            dco = 1'b1;
        end else if (!sclk) begin
            dco = 1'b0;
            if (TWO_LANE == 0) lane_b = lcg[21];
        end
        if (sample_valid) begin
            check(!val_p, "R7 valid width", val_p, 0);
            got = sample_data;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected sample", got, 0);
            end else begin
                tpw = tp_word.pop_front();
                check(got == exp_q[0],
                      tpw ? "R10 pattern word" : ((TWO_LANE != 0) ? "R5 two-lane word" : "R6 one-lane word"),
                      got, exp_q[0]);
                void'(exp_q.pop_front());
                n_samp++;
            end
        end
        cnv_p  = cnv;
        sclk_p = sclk;
        val_p  = sample_valid;
    end
endmodule

// File: tb/test_adc_serial_capture.sv
// Bench: two capture instances (two-lane default and one-lane), each with
// a converter model acting as driver and scoreboard monitor.
module test_adc_serial_capture;
    localparam int DW = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en0 = 1'b0, en1 = 1'b0, pd_req = 1'b0, tp_req = 1'b0;

    logic dco0, la0, lb0, cnv0, cnven0, sclk0, gate0, lsel0, pd0, tp0, val0;
    logic dco1, la1, lb1, cnv1, cnven1, sclk1, gate1, lsel1, pd1, tp1, val1;
    logic [DW-1:0] data0, data1;
    int chk0, fail0, samp0, chk1, fail1, samp1;
    int chks = 0, fails = 0;
    bit quiet;

    always #4 clk = ~clk;

    adc_serial_capture i_adc_serial_capture (
        .clk(clk), .rst_n(rst_n), .enable(en0), .pd_req(pd_req),
        .testpat_req(tp_req), .dco(dco0), .lane_a(la0), .lane_b(lb0),
        .cnv(cnv0), .cnv_en(cnven0), .sclk(sclk0), .sclk_gate(gate0),
        .lanes_sel(lsel0), .pd_out(pd0), .testpat_out(tp0),
        .sample_data(data0), .sample_valid(val0)
    );

    adc_serial_capture #(
        .TWO_LANE(0), .PERIOD(48), .CNV_HIGH(3), .CONV_WAIT(6)
    ) i_adc_serial_capture_one (
        .clk(clk), .rst_n(rst_n), .enable(en1), .pd_req(pd_req),
        .testpat_req(tp_req), .dco(dco1), .lane_a(la1), .lane_b(lb1),
        .cnv(cnv1), .cnv_en(cnven1), .sclk(sclk1), .sclk_gate(gate1),
        .lanes_sel(lsel1), .pd_out(pd1), .testpat_out(tp1),
        .sample_data(data1), .sample_valid(val1)
    );

    adc_conv_model #(.TWO_LANE(1), .PERIOD(32), .CNV_HIGH(2), .CONV_WAIT(8), .SEED(7)) u_model0 (
        .clk(clk), .cnv(cnv0), .cnv_en(cnven0), .sclk(sclk0), .testpat(tp0),
        .sample_valid(val0), .sample_data(data0), .dco(dco0), .lane_a(la0),
        .lane_b(lb0), .n_chk(chk0), .n_fail(fail0), .n_samp(samp0)
    );

    adc_conv_model #(.TWO_LANE(0), .PERIOD(48), .CNV_HIGH(3), .CONV_WAIT(6), .SEED(91)) u_model1 (
        .clk(clk), .cnv(cnv1), .cnv_en(cnven1), .sclk(sclk1), .testpat(tp1),
        .sample_valid(val1), .sample_data(data1), .dco(dco1), .lane_a(la1),
        .lane_b(lb1), .n_chk(chk1), .n_fail(fail1), .n_samp(samp1)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        chks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_samples(input int s0, input int s1);
        while (samp0 < s0 || samp1 < s1) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (5) @(negedge clk);
                // R2 reset state, R9 control outputs cleared
                check({cnv0, gate0, val0, cnven0, pd0, tp0} == 6'b0, "R2 reset state inst0",
                      {cnv0, gate0, val0, cnven0, pd0, tp0}, 0);
                check({cnv1, gate1, val1, cnven1, pd1, tp1} == 6'b0, "R9 reset state inst1",
                      {cnv1, gate1, val1, cnven1, pd1, tp1}, 0);
                rst_n = 1'b1;
                @(negedge clk);
                check(lsel0 == 1'b1, "R8 lanes_sel two-lane", lsel0, 1);
                check(lsel1 == 1'b0, "R8 lanes_sel one-lane", lsel1, 0);
                en0 = 1'b1;
                en1 = 1'b1;
                @(negedge clk);
                check(cnven0 && cnven1, "R2 cnv_en follows enable", {cnven0, cnven1}, 3);
                wait_samples(8, 6);
                tp_req = 1'b1;
                @(negedge clk);
                check(tp0 && tp1, "R9 testpat_out", {tp0, tp1}, 3);
                wait_samples(samp0 + 3, samp1 + 3);
                tp_req = 1'b0;
                pd_req = 1'b1;
                @(negedge clk);
                check(pd0 && pd1 && !tp0, "R9 pd_out", {pd0, pd1, tp0}, 6);
                pd_req = 1'b0;
                @(negedge clk);
                check(!pd0, "R9 pd_out release", pd0, 0);
                wait_samples(samp0 + 2, samp1 + 1);
                while (!val0) @(negedge clk);
                en0 = 1'b0;
                @(negedge clk);
                quiet = 1'b1;
                for (int i = 0; i < 60; i++) begin
                    if (cnven0 || cnv0 || sclk0 || gate0) quiet = 1'b0;
                    @(negedge clk);
                end
                check(quiet, "R2 silent while disabled", quiet, 1);
                en0 = 1'b1;
                wait_samples(samp0 + 4, samp1 + 2);
            end
            begin
                repeat (150000) @(negedge clk);
                chks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        chks  += chk0 + chk1;
        fails += fail0 + fail1;
        $display("== %0d vectors applied, %0d miscompares ==", chks, fails);
        $finish;
    end
endmodule